// File: doc/BRIEF.md
# UART Baud Clock Generator

This block derives the bit-rate timing for an asynchronous serial transmitter and receiver from the system clock. It has two dividing stages. A prescaler turns the system clock into a base-clock enable strobe whose period is a power of two, chosen by a 4-bit select code. A programmable 8-bit divider then counts base strobes and emits one baud tick each time it reaches the programmed divisor.

Software sets both stages through two byte-wide registers on a simple write/read port. The serial unit's enable input gates the whole block. While the enable is high, both settings are frozen and the counters run. When the enable is low, both counters are cleared, so every enable period starts from a known phase. Two kinds of setting produce no timing. A select code that is prohibited, or that would give a base clock faster than the allowed maximum, is refused and raises a sticky error flag. A divisor below 2 yields no ticks.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset the select register reads 0x00, the divisor register reads 0x00, `cfg_err` is 0, and `base_stb` and `baud_tick` are 0.
- R2: `reg_addr`=0 addresses the select register: bits 3..0 hold the code, and bits 7..4 are not stored and read as 0. `reg_addr`=1 addresses the 8-bit divisor register. `reg_rdata` shows the addressed register in the same cycle.
- R3: While `uart_en` is 1 and the select code is c (0 to 11), `base_stb` is high for exactly one cycle in every 2^c cycles. Counting the first enabled cycle as cycle 0, the strobes fall in cycles 2^c-1, 2*2^c-1, and so on.
- R4: Writing a select code from 12 to 15 leaves the select register unchanged and sets `cfg_err`. Once set, `cfg_err` is cleared only by reset and survives later legal writes.
- R5: A select code whose base clock, SYS_CLK_HZ / 2^code, would exceed MAX_BASE_HZ is refused in the same way as R4. For example, with a 40 MHz system clock and a 20 MHz limit, code 0 is refused.
- R6: A register write in a cycle where `uart_en` is 1 is ignored. Both registers and `cfg_err` keep their previous values.
- R7: With a divisor d of 2 or more, `baud_tick` rises only in a cycle where `base_stb` is high, once for every d base strobes. Its period is therefore 2^c·d cycles.
- R8: A divisor of 0 or 1 produces no `baud_tick` at all, while `base_stb` keeps running.
- R9: When `uart_en` is 0, both counters are cleared synchronously and both strobes are 0. After `uart_en` rises again, the first tick falls in cycle 2^c·d-1, whatever phase the counters were in before the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_en | input | 1 | Serial unit enable; runs the counters and locks the registers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 is the select code, 1 is the divisor |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| base_stb | output | 1 | Base-clock enable strobe, one cycle wide |
| baud_tick | output | 1 | Baud tick strobe, one cycle wide |
| cfg_err | output | 1 | Sticky flag for a refused select code |

## Verification
The two events that can share a cycle are a register write and a change of `uart_en`. The bench raises the enable in the same cycle as a write and expects the write to be dropped. In the cycle right after the enable falls, it expects a write to be taken. It judges both cases by reading the registers back. A second coincidence is the baud tick with its base strobe. Every tick must land on a strobe, and the bench checks this by comparing measured strobe and tick counts, and the position of the first tick, against 2^c and 2^c·d.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   localparam int BG_REG_W = 8;
   localparam int BG_DIV_W = 8;

   localparam logic BG_ADDR_SEL = 1'b0;
   localparam logic BG_ADDR_DIV = 1'b1;

   // lowest select code whose base clock respects the frequency ceiling
   function automatic int bg_min_code(input longint sys_hz,
                                      input longint max_hz,
                                      input int     top_code);
      int res;
      res = top_code + 1;
      for (int c = top_code; c >= 0; c--) begin
         if ((sys_hz >> c) <= max_hz) res = c;
      end
      return res;
   endfunction

endpackage

// File: rtl/bg_regs.sv
module bg_regs
   import baud_gen_pkg::*;
#(
   parameter int SEL_W    = 4,
   parameter int TOP_CODE = 11,
   parameter int MIN_CODE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                uart_en,
   input  logic                reg_wr,
   input  logic                reg_addr,
   input  logic [BG_REG_W-1:0] reg_wdata,
   output logic [BG_REG_W-1:0] reg_rdata,
   output logic [SEL_W-1:0]    sel_q,
   output logic [BG_DIV_W-1:0] div_q,
   output logic                err_q
);

   localparam int NCODE = 2 ** SEL_W;

   logic [NCODE-1:0] code_ok;
   logic [SEL_W-1:0] wr_sel;
   logic             wr_open;

   // constant legality map, one bit per possible select code
   for (genvar g = 0; g < NCODE; g++) begin : g_ok
      if (g >= MIN_CODE && g <= TOP_CODE) begin : g_legal
         assign code_ok[g] = 1'b1;
      end else begin : g_refused
         assign code_ok[g] = 1'b0;
      end
   end

   assign wr_sel  = reg_wdata[SEL_W-1:0];
   assign wr_open = reg_wr & ~uart_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         div_q <= '0;
         err_q <= 1'b0;
      end else if (wr_open) begin
         if (reg_addr == BG_ADDR_SEL) begin
            if (code_ok[wr_sel]) begin
               sel_q <= wr_sel;
            end else begin
               err_q <= 1'b1;
            end
         end else begin
            div_q <= reg_wdata[BG_DIV_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == BG_ADDR_DIV) begin
         reg_rdata[BG_DIV_W-1:0] = div_q;
      end else begin
         reg_rdata[SEL_W-1:0] = sel_q;
      end
   end

endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
   parameter int SEL_W    = 4,
   parameter int TOP_CODE = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             stb
);

   localparam int NCODE = 2 ** SEL_W;
   localparam int CNT_W = (TOP_CODE < 1) ? 1 : TOP_CODE;

   logic [CNT_W-1:0] cnt;
   logic [NCODE-1:0] tap;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   // tap g fires when the low g bits of the running count are all ones
   for (genvar g = 0; g < NCODE; g++) begin : g_tap
      if (g == 0) begin : g_every
         assign tap[g] = 1'b1;
      end else if (g <= TOP_CODE) begin : g_pow
         assign tap[g] = &cnt[g-1:0];
      end else begin : g_none
         assign tap[g] = 1'b0;
      end
   end

   assign stb = run & tap[sel];

endmodule

// File: rtl/bg_divider.sv
module bg_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             base_stb,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] dcnt;
   logic             at_end;
   logic             div_ok;

   assign at_end = (dcnt == (div - DIV_W'(1)));
   assign div_ok = (div > DIV_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         dcnt <= '0;
      end else if (base_stb) begin
         if (at_end) begin
            dcnt <= '0;
         end else begin
            dcnt <= dcnt + DIV_W'(1);
         end
      end
   end

   assign tick = run & base_stb & div_ok & at_end;

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
   import baud_gen_pkg::*;
#(
   parameter longint SYS_CLK_HZ  = 20_000_000,
   parameter longint MAX_BASE_HZ = 20_000_000,
   parameter int     SEL_W       = 4,
   parameter int     TOP_CODE    = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                uart_en,
   input  logic                reg_wr,
   input  logic                reg_addr,
   input  logic [BG_REG_W-1:0] reg_wdata,
   output logic [BG_REG_W-1:0] reg_rdata,
   output logic                base_stb,
   output logic                baud_tick,
   output logic                cfg_err
);

   localparam int MIN_CODE = bg_min_code(SYS_CLK_HZ, MAX_BASE_HZ, TOP_CODE);

   if (SEL_W > BG_REG_W) begin : g_chk_selw
      $error("select field wider than its register");
   end
   if (TOP_CODE >= 2 ** SEL_W || TOP_CODE < 1) begin : g_chk_top
      $error("TOP_CODE out of range for SEL_W");
   end
   if (MIN_CODE > TOP_CODE) begin : g_chk_min
      $error("no select code meets MAX_BASE_HZ");
   end

   logic [SEL_W-1:0]    sel_q;
   logic [BG_DIV_W-1:0] div_q;

   bg_regs #(
      .SEL_W   (SEL_W),
      .TOP_CODE(TOP_CODE),
      .MIN_CODE(MIN_CODE)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .uart_en  (uart_en),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .sel_q    (sel_q),
      .div_q    (div_q),
      .err_q    (cfg_err)
   );

   bg_prescaler #(
      .SEL_W   (SEL_W),
      .TOP_CODE(TOP_CODE)
   ) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (uart_en),
      .sel  (sel_q),
      .stb  (base_stb)
   );

   bg_divider #(
      .DIV_W(BG_DIV_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (uart_en),
      .base_stb(base_stb),
      .div     (div_q),
      .tick    (baud_tick)
   );

endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk #(
   parameter int SEL_W    = 4,
   parameter int TOP_CODE = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             uart_en,
   input logic             reg_wr,
   input logic             reg_addr,
   input logic [7:0]       reg_rdata,
   input logic             base_stb,
   input logic             baud_tick,
   input logic             cfg_err,
   input logic [SEL_W-1:0] sel_q,
   input logic [7:0]       div_q
);

   p_tick_on_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> base_stb);

   p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !uart_en |-> (!base_stb && !baud_tick));

   p_locked_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      uart_en |=> ($stable(sel_q) && $stable(div_q)));

   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

   p_sel_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_q) <= TOP_CODE));

   p_small_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q < 8'd2) |-> !baud_tick);

   p_high_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_addr && !reg_wr) |-> (reg_rdata[7:SEL_W] == '0));

endmodule

bind baud_rate_gen baud_rate_gen_chk #(
   .SEL_W   (SEL_W),
   .TOP_CODE(TOP_CODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .uart_en  (uart_en),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_rdata(reg_rdata),
   .base_stb (base_stb),
   .baud_tick(baud_tick),
   .cfg_err  (cfg_err),
   .sel_q    (sel_q),
   .div_q    (div_q)
);

// File: tb/baud_rate_gen_tb.sv
module baud_rate_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       uart_en = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       base_stb, baud_tick, cfg_err;

   logic       f_wr = 1'b0;
   logic       f_addr = 1'b0;
   logic [7:0] f_wdata = 8'h00;
   logic [7:0] f_rdata;
   logic       f_base, f_tick, f_err;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   baud_rate_gen u_dut (
      .clk(clk), .rst_n(rst_n), .uart_en(uart_en),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .base_stb(base_stb), .baud_tick(baud_tick),
      .cfg_err(cfg_err)
   );

   // 40 MHz system clock against a 20 MHz ceiling: code 0 is refused
   baud_rate_gen #(.SYS_CLK_HZ(40_000_000), .MAX_BASE_HZ(20_000_000)) u_fast (
      .clk(clk), .rst_n(rst_n), .uart_en(1'b0),
      .reg_wr(f_wr), .reg_addr(f_addr), .reg_wdata(f_wdata),
      .reg_rdata(f_rdata), .base_stb(f_base), .baud_tick(f_tick),
      .cfg_err(f_err)
   );

   // code, divisor, cycles, expected base strobes, expected ticks
   localparam int NVEC = 7;
   localparam int VEC [NVEC][5] = '{
      '{0,   2,   40, 40, 20},
      '{1,   3,   60, 30, 10},
      '{3,   5,  200, 25,  5},
      '{11,  2, 8192,  4,  2},
      '{2, 255, 2040,510,  2},
      '{0,   1,   50, 50,  0},
      '{0,   0,   50, 50,  0}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic a, output logic [7:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic f_wr_reg(input logic a, input logic [7:0] d);
      f_addr = a; f_wdata = d; f_wr = 1'b1;
      @(negedge clk);
      f_wr = 1'b0;
   endtask

   // enables for n cycles, sampling each cycle before its rising edge
   task automatic run_count(input int n, output int nb, output int nt);
      nb = 0; nt = 0;
      uart_en = 1'b1;
      for (int k = 0; k < n; k++) begin
         #1;
         if (base_stb) nb++;
         if (baud_tick) nt++;
         @(negedge clk);
      end
      uart_en = 1'b0;
   endtask

   // enables and returns the cycle index of the first tick
   task automatic first_tick(input int limit, output int idx);
      idx = -1;
      uart_en = 1'b1;
      for (int k = 0; k < limit; k++) begin
         #1;
         if (baud_tick && idx < 0) idx = k;
         @(negedge clk);
      end
      uart_en = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int nb, nt, idx;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_reg(1'b0, v); check("R1 select reset", v, 8'h00);
      rd_reg(1'b1, v); check("R1 divisor reset", v, 8'h00);
      check("R1 err reset", cfg_err, 0);
      check("R1 base idle", base_stb, 0);
      check("R1 tick idle", baud_tick, 0);
      @(negedge clk);

      // R3 R7 R8 vector walk
      for (int i = 0; i < NVEC; i++) begin
         wr_reg(1'b0, 8'(VEC[i][0]));
         wr_reg(1'b1, 8'(VEC[i][1]));
         run_count(VEC[i][2], nb, nt);
         check($sformatf("R3 base count vec%0d", i), nb, VEC[i][3]);
         check($sformatf("R7 R8 tick count vec%0d", i), nt, VEC[i][4]);
         @(negedge clk);
      end

      // R2 field layout
      wr_reg(1'b0, 8'hF5);
      rd_reg(1'b0, v); check("R2 high nibble dropped", v, 8'h05);
      wr_reg(1'b1, 8'hA7);
      rd_reg(1'b1, v); check("R2 divisor readback", v, 8'hA7);

      // R4 prohibited codes, sticky flag
      wr_reg(1'b0, 8'h0C);
      rd_reg(1'b0, v); check("R4 code 12 refused", v, 8'h05);
      check("R4 err raised", cfg_err, 1);
      wr_reg(1'b0, 8'h0F);
      rd_reg(1'b0, v); check("R4 code 15 refused", v, 8'h05);
      wr_reg(1'b0, 8'h03);
      rd_reg(1'b0, v); check("R4 legal after error", v, 8'h03);
      check("R4 err sticky", cfg_err, 1);

      // R6 writes while enabled; first write shares the enable's cycle
      uart_en = 1'b1;
      wr_reg(1'b0, 8'h07);
      wr_reg(1'b1, 8'h09);
      rd_reg(1'b0, v); check("R6 select locked", v, 8'h03);
      rd_reg(1'b1, v); check("R6 divisor locked", v, 8'hA7);
      uart_en = 1'b0;
      wr_reg(1'b0, 8'h02);
      rd_reg(1'b0, v); check("R6 write after disable taken", v, 8'h02);

      // R9 first tick position and restart from a cleared phase
      wr_reg(1'b1, 8'h03);
      first_tick(20, idx);
      check("R9 first tick index", idx, 11);
      @(negedge clk);
      uart_en = 1'b1;
      repeat (7) @(negedge clk);
      uart_en = 1'b0;
      @(negedge clk);
      #1 check("R9 strobes clear when idle", base_stb | baud_tick, 0);
      @(negedge clk);
      first_tick(20, idx);
      check("R9 restart first tick", idx, 11);

      // R5 frequency ceiling on the 40 MHz instance
      f_wr_reg(1'b0, 8'h01);
      f_addr = 1'b0;
      #1 check("R5 code 1 accepted", f_rdata, 8'h01);
      check("R5 no err on legal", f_err, 0);
      @(negedge clk);
      f_wr_reg(1'b0, 8'h00);
      f_addr = 1'b0;
      #1 check("R5 code 0 refused", f_rdata, 8'h01);
      check("R5 err raised", f_err, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule